// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN identifier is taken into the receive path. It holds no registers of its own apart from the result. Each cycle it sees the four identifier bytes of the frame, a bank of eight acceptance bytes, a matching bank of eight mask bytes, and a 2-bit mode select. When the valid strobe is high, the block registers an accept flag and the index of the filter that matched.

The same bank is read in one of four ways, chosen by the mode. It can act as two 32-bit filters, four 16-bit filters or eight 8-bit filters, or the filter can be closed. A mask bit at 1 turns off the comparison of that bit position. When more than one filter matches, the lowest-numbered one is reported.

The identifier layout is fixed:

- Byte 0 carries ID28..ID21.
- Byte 1 carries ID20..ID18 in bits 7..5, the SRR/RTR flag in bit 4, IDE in bit 3 and ID17..ID15 in bits 2..0.
- Byte 2 carries ID14..ID7.
- Byte 3 carries ID6..ID0 in bits 7..1 and RTR in bit 0.

Top module: `can_id_filter`

## Requirements
- R1: A mask bit of 1 makes the matching acceptance bit don't-care. A mask bit of 0 requires the identifier bit to equal the acceptance bit.
- R2: Vector packing and 32-bit mode:
  - Identifier byte b sits at `id_i[8b+7:8b]`, acceptance byte k at `acc_i[8k+7:8k]` and mask byte k at `mask_i[8k+7:8k]`.
  - With `mode_i` = 2'b00, filter f (0..1) compares bank bytes 4f+j with identifier bytes j, for j = 0..3.
- R3: With `mode_i` = 2'b01, filter f (0..3) compares bank byte 2f with identifier byte 0, and bank byte 2f+1 with identifier byte 1.
- R4: With `mode_i` = 2'b10, filter f (0..7) compares bank byte f with identifier byte 0.
- R5: With `mode_i` = 2'b11 the filter is closed: every strobe gives `accept_o` = 0 and `hit_o` = 0.
- R6: When several filters match, `hit_o` gives the lowest filter index.
- R7: `accept_o` is high for exactly one cycle, in the cycle after a strobe that matched. Without a strobe it stays low, whatever the other inputs are.
- R8: Hit index behaviour:
  - `hit_o` is loaded on every strobe, and is loaded with 0 when the strobe is rejected.
  - Between strobes, `hit_o` holds its value while the identifier, bank and mode change.
- R9: While `rst_ni` is low, `accept_o` and `hit_o` are 0.
- R10: In 16-bit mode, take a filter whose byte-1 bit 3 (IDE) acceptance bit is 1 and unmasked:
  - It rejects frames with IDE = 0.
  - If byte-1 bit 4 (RTR) is masked as well, it accepts both RTR values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Identifier strobe |
| id_i | input | 32 | Identifier bytes 0..3 |
| acc_i | input | 64 | Acceptance bytes 0..7 |
| mask_i | input | 64 | Mask bytes 0..7, 1 = don't care |
| mode_i | input | 2 | 00 two 32-bit, 01 four 16-bit, 10 eight 8-bit, 11 closed |
| accept_o | output | 1 | Identifier accepted, one-cycle pulse |
| hit_o | output | 3 | Index of the matching filter |

## Verification
Both results come out of a single register stage. A strobe driven before clock edge N therefore shows on `accept_o` and `hit_o` after edge N.

The bench drives each strobe on a falling edge and samples on the next falling edge, one clock after the strobe. It samples again one cycle later to confirm that the accept pulse has dropped. For the hold behaviour of `hit_o`, it samples several idle cycles after the strobe, with the identifier, bank and mode changed in between.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  typedef enum logic [1:0] {
    MODE_W32 = 2'b00,
    MODE_W16 = 2'b01,
    MODE_W8  = 2'b10,
    MODE_OFF = 2'b11
  } filt_mode_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/can_filt_byte_cmp.sv
module can_filt_byte_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] id_byte_i,
  input  logic [W-1:0] acc_byte_i,
  input  logic [W-1:0] mask_byte_i,
  output logic         match_o
);
  // masked bits never contribute a difference
  assign match_o = ~|((id_byte_i ^ acc_byte_i) & ~mask_byte_i);
endmodule

// File: rtl/can_filt_group.sv
module can_filt_group import can_filt_pkg::*; #(
  parameter int BANK_BYTES = 8,
  parameter int ID_BYTES   = 4
) (
  input  logic [BANK_BYTES-1:0] byte_match_i,
  input  logic [1:0]            mode_i,
  output logic [BANK_BYTES-1:0] hit_vec_o
);
  localparam int G16 = ID_BYTES / 2;
  localparam int N32 = BANK_BYTES / ID_BYTES;
  localparam int N16 = BANK_BYTES / G16;

  logic [N32-1:0] w32;
  logic [N16-1:0] w16;

  for (genvar f = 0; f < N32; f++) begin : g_w32
    assign w32[f] = &byte_match_i[f*ID_BYTES +: ID_BYTES];
  end
  for (genvar f = 0; f < N16; f++) begin : g_w16
    assign w16[f] = &byte_match_i[f*G16 +: G16];
  end

  always_comb begin
    hit_vec_o = '0;
    case (mode_i)
      MODE_W32: hit_vec_o[N32-1:0] = w32;
      MODE_W16: hit_vec_o[N16-1:0] = w16;
      MODE_W8:  hit_vec_o = byte_match_i;
      default:  hit_vec_o = '0;
    endcase
  end
endmodule

// File: rtl/can_filt_prio_enc.sv
module can_filt_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    // scan downward so the lowest set index wins
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter import can_filt_pkg::*; #(
  parameter int BANK_BYTES = 8,
  parameter int ID_BYTES   = 4,
  localparam int HIT_W     = $clog2(BANK_BYTES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [BYTE_W*ID_BYTES-1:0]   id_i,
  input  logic [BYTE_W*BANK_BYTES-1:0] acc_i,
  input  logic [BYTE_W*BANK_BYTES-1:0] mask_i,
  input  logic [1:0]                   mode_i,
  output logic                         accept_o,
  output logic [HIT_W-1:0]             hit_o
);
  localparam int G16 = ID_BYTES / 2;

  logic [BANK_BYTES-1:0] byte_match;
  logic [BANK_BYTES-1:0] hit_vec;
  logic                  any_hit;
  logic [HIT_W-1:0]      hit_idx;

  // steer the identifier byte each bank byte faces, per filter width
  for (genvar k = 0; k < BANK_BYTES; k++) begin : g_byte
    localparam int I32 = k % ID_BYTES;
    localparam int I16 = k % G16;
    logic [BYTE_W-1:0] id_sel;

    always_comb begin
      case (mode_i)
        MODE_W32: id_sel = id_i[BYTE_W*I32 +: BYTE_W];
        MODE_W16: id_sel = id_i[BYTE_W*I16 +: BYTE_W];
        default:  id_sel = id_i[BYTE_W-1:0];
      endcase
    end

    can_filt_byte_cmp #(.W(BYTE_W)) u_cmp (
      .id_byte_i  (id_sel),
      .acc_byte_i (acc_i[BYTE_W*k +: BYTE_W]),
      .mask_byte_i(mask_i[BYTE_W*k +: BYTE_W]),
      .match_o    (byte_match[k])
    );
  end

  can_filt_group #(.BANK_BYTES(BANK_BYTES), .ID_BYTES(ID_BYTES)) u_group (
    .byte_match_i(byte_match),
    .mode_i      (mode_i),
    .hit_vec_o   (hit_vec)
  );

  can_filt_prio_enc #(.N(BANK_BYTES), .IDX_W(HIT_W)) u_prio (
    .vec_i(hit_vec),
    .any_o(any_hit),
    .idx_o(hit_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      hit_o    <= '0;
    end else begin
      accept_o <= valid_i & any_hit;
      if (valid_i) hit_o <= any_hit ? hit_idx : '0;
    end
  end
endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
  parameter int BANK_BYTES = 8,
  parameter int ID_BYTES   = 4,
  localparam int HIT_W     = $clog2(BANK_BYTES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       mode_i,
  input logic             accept_o,
  input logic [HIT_W-1:0] hit_o
);
  localparam int N32 = BANK_BYTES / ID_BYTES;
  localparam int N16 = BANK_BYTES / (ID_BYTES / 2);

  p_accept_needs_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(valid_i));

  p_closed_rejects_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> ($past(mode_i) != 2'b11));

  p_hit_range_w32_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(mode_i) == 2'b00) |-> (int'(hit_o) < N32));

  p_hit_range_w16_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(mode_i) == 2'b01) |-> (int'(hit_o) < N16));

  p_hit_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(hit_o));

  p_reject_zero_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && !accept_o) |-> (hit_o == '0));
endmodule

bind can_id_filter can_id_filter_chk #(.BANK_BYTES(BANK_BYTES), .ID_BYTES(ID_BYTES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .mode_i  (mode_i),
  .accept_o(accept_o),
  .hit_o   (hit_o)
);

// File: tb/can_id_filter_tb.sv
module can_id_filter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] id_i = '0;
  logic [63:0] acc_i = '0;
  logic [63:0] mask_i = '0;
  logic [1:0]  mode_i = 2'b00;
  logic        accept_o;
  logic [2:0]  hit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5679;

  always #4 clk_i = ~clk_i;

  can_id_filter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .id_i(id_i),
    .acc_i(acc_i), .mask_i(mask_i), .mode_i(mode_i),
    .accept_o(accept_o), .hit_o(hit_o)
  );

  task automatic chk(input string req, input logic ga, input logic [2:0] gh,
                     input logic ea, input logic [2:0] eh);
    n_chk++;
    if (ga !== ea || gh !== eh) begin
      n_bad++;
      $display("FAIL %s: got accept=%0b hit=%0d, expected accept=%0b hit=%0d",
               req, ga, gh, ea, eh);
    end
  endtask

  // strobe one identifier; results sampled one clock later
  task automatic strobe(input logic [31:0] id);
    @(negedge clk_i);
    id_i = id;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  function automatic logic [3:0] model(input logic [1:0] m, input logic [63:0] a,
                                       input logic [63:0] k, input logic [31:0] id);
    int n, w;
    case (m)
      2'b00: begin n = 2; w = 4; end
      2'b01: begin n = 4; w = 2; end
      2'b10: begin n = 8; w = 1; end
      default: return 4'b0;
    endcase
    for (int f = 0; f < n; f++) begin
      bit ok = 1'b1;
      for (int j = 0; j < w; j++)
        if (((a[8*(f*w+j) +: 8] ^ id[8*j +: 8]) & ~k[8*(f*w+j) +: 8]) != 8'h00) ok = 1'b0;
      if (ok) return {1'b1, 3'(f)};
    end
    return 4'b0;
  endfunction

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic t_reset();
    @(negedge clk_i);
    chk("R9 reset", accept_o, hit_o, 1'b0, 3'd0);
  endtask

  task automatic t_w32();
    mode_i = 2'b00; mask_i = '0;
    acc_i = {32'h8899_AABB, 32'h1122_3344};
    strobe(32'h8899_AABB);
    chk("R2 filter 1", accept_o, hit_o, 1'b1, 3'd1);
    strobe(32'h1122_3344);
    chk("R2 filter 0", accept_o, hit_o, 1'b1, 3'd0);
    strobe(32'h1122_3345);
    chk("R2 byte 0 mismatch", accept_o, hit_o, 1'b0, 3'd0);
  endtask

  task automatic t_mask_bits();
    mode_i = 2'b10;
    acc_i = 64'h0101_0101_0101_0101; mask_i = '0;
    acc_i[8*3 +: 8] = 8'hC3; mask_i[8*3 +: 8] = 8'h10;
    strobe(32'h0000_00D3);
    chk("R1 masked bit differs", accept_o, hit_o, 1'b1, 3'd3);
    strobe(32'h0000_00C7);
    chk("R1 unmasked bit differs", accept_o, hit_o, 1'b0, 3'd0);
  endtask

  task automatic t_w16_ide();
    mode_i = 2'b01; acc_i = '0; mask_i = '0;
    acc_i[7:0] = 8'h5A; acc_i[15:8] = 8'hA8; mask_i[15:8] = 8'h07;
    acc_i[8*6 +: 8] = 8'h33; acc_i[8*7 +: 8] = 8'h44;
    strobe(32'h0000_A85A);
    chk("R10 IDE=1 accepted", accept_o, hit_o, 1'b1, 3'd0);
    strobe(32'h0000_A05A);
    chk("R10 IDE=0 rejected", accept_o, hit_o, 1'b0, 3'd0);
    strobe(32'h0000_B85A);
    chk("R10 RTR unmasked rejects", accept_o, hit_o, 1'b0, 3'd0);
    mask_i[15:8] = 8'h17;
    strobe(32'h0000_B85A);
    chk("R10 RTR masked accepts", accept_o, hit_o, 1'b1, 3'd0);
    strobe(32'hFFFF_4433);
    chk("R3 filter 3 on bytes 0/1", accept_o, hit_o, 1'b1, 3'd3);
  endtask

  task automatic t_w8();
    mode_i = 2'b10; mask_i = '0;
    acc_i = 64'h7766_5544_3322_1100;
    strobe(32'hEEEE_EE55);
    chk("R4 filter 5", accept_o, hit_o, 1'b1, 3'd5);
    @(negedge clk_i);
    chk("R7 pulse one cycle", accept_o, hit_o, 1'b0, 3'd5);
  endtask

  task automatic t_hold();
    // hit_o = 5 from previous strobe
    mode_i = 2'b11; id_i = 32'h0000_0011; mask_i = '1;
    repeat (3) @(negedge clk_i);
    chk("R8 hold between strobes", accept_o, hit_o, 1'b0, 3'd5);
    mode_i = 2'b10; acc_i = 64'h7766_5544_3322_1100; mask_i = '0;
    id_i = 32'h0000_0077;
    repeat (2) @(negedge clk_i);
    chk("R7 no accept without strobe", accept_o, hit_o, 1'b0, 3'd5);
    strobe(32'h0000_00F0);
    chk("R8 reject clears hit", accept_o, hit_o, 1'b0, 3'd0);
  endtask

  task automatic t_closed_prio();
    mask_i = '1;
    mode_i = 2'b11;
    strobe(32'hDEAD_BEEF);
    chk("R5 closed", accept_o, hit_o, 1'b0, 3'd0);
    mode_i = 2'b10;
    strobe(32'hDEAD_BEEF);
    chk("R6 lowest of eight", accept_o, hit_o, 1'b1, 3'd0);
    mask_i = '0; acc_i = 64'h0000_0000_0000_0000;
    acc_i[8*4 +: 8] = 8'h21; acc_i[8*6 +: 8] = 8'h21; acc_i[8*7 +: 8] = 8'h21;
    strobe(32'h0000_0021);
    chk("R6 lowest of 4,6,7", accept_o, hit_o, 1'b1, 3'd4);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 48; i++) begin
      logic [3:0] e;
      mode_i = 2'(i % 4);
      acc_i = {rnd(), rnd()};
      mask_i = {rnd() | rnd(), rnd() | rnd()};
      id_i = rnd();
      e = model(mode_i, acc_i, mask_i, id_i);
      strobe(id_i);
      chk("R1 R2 R3 R4 R5 sweep", accept_o, hit_o, e[3], e[2:0]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 after release", accept_o, hit_o, 1'b0, 3'd0);
    t_w32();
    t_mask_bits();
    t_w16_ide();
    t_w8();
    t_hold();
    t_closed_prio();
    t_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule